// File: doc/BRIEF.md
# Network Port Status Lamp Driver

This block turns the state of a network port into three lamp levels: one for link, one for line speed and one for traffic. Link state and speed arrive as steady levels. Traffic arrives as short strobes from the transmit and receive paths, and the two strobes are treated the same way. A one-bit style input picks between two behaviours. In the merged style the link lamp also shows traffic by blinking slowly. In the split style the link lamp stays steady and only the traffic lamp blinks.

All blinking comes from one prescaler that divides the system clock down to a toggle tick. The clock frequency and the tick rate are parameters. One tick step is one on or off phase of the fast blink, so a 40 Hz tick gives a 20 Hz traffic blink and a 10 Hz merged link blink. A test input shortens the tick interval by a fixed factor, 8192 by default, so that blinking can be seen within a short run. A traffic strobe re-arms a hold timer. A single short packet therefore still gives a full blink cycle, and each new burst starts its blink pattern from the same phase.

Top module: `phy_led_ctrl`

## Requirements
- R1: While reset is asserted, the link lamp and the traffic lamp are driven low from the first clock edge onward, whatever the other inputs do.
- R2: The speed lamp shows the value of speed_100 sampled at the previous clock edge (1 means 100 Mb/s: lamp on; 0 means 10 Mb/s: lamp off). This holds during reset and whether or not the link is up.
- R3: While link_up is 0, the link lamp and the traffic lamp are low one cycle later, even while traffic strobes arrive.
- R4: With style input 1 (split), the link lamp is high one cycle after any cycle with link_up high, and traffic does not affect it.
- R5: With style input 0 (merged) and the link up, the link lamp is steadily on while there is no traffic. During traffic, after edge En of a burst it equals 1 when ((n-1)/D) mod 4 is 0 or 1, and 0 otherwise.
- R6: The traffic lamp blinks only while traffic is held and the link is up. After edge En of a burst it is on when ((n-1)/D) is even and off when it is odd. It is off after E0 and behaves the same in both styles.
- R7: A strobe seen while no traffic is held starts a burst at edge E0. It clears the blink phase and the prescaler and arms a hold of HOLD_TICKS ticks. A later strobe reloads the hold but keeps the phase. Ticks occur at edges E(D*j), j >= 1. Traffic stays held up to and including edge T = D*(L/D + HOLD_TICKS), where L is the index of the last strobe edge.
- R8: A strobe on rx_activity has the same effect as one on tx_activity.
- R9: The tick interval D is CLK_HZ/TOGGLE_HZ cycles with the test input low. With the test input high it is that value divided by TEST_FACTOR, at least 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is good |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| tx_activity | input | 1 | Transmit traffic strobe |
| rx_activity | input | 1 | Receive traffic strobe |
| mode | input | 1 | Lamp style: 0 merged link/traffic, 1 split |
| blink_test | input | 1 | Shortens every blink interval by TEST_FACTOR |
| led_link | output | 1 | Link lamp level |
| led_speed | output | 1 | Speed lamp level |
| led_act | output | 1 | Traffic lamp level |

## Verification
On every cycle the assertions check the following: the lamps are dark in reset and with the link down, the speed lamp tracks its input, the split-style link lamp stays steady, and the merged link lamp stays steady when no traffic is held. They also check that a strobe always arms the hold and that the traffic lamp lights only while traffic is held. Some behaviours need the bench scenarios instead. These are the exact blink phase in each cycle of a burst, the point where the hold ends after a re-armed burst, that phase is kept across a re-arm, and the tick interval in both the normal and the test setting. The bench computes these from the burst formulas for single pulses, long strobes and re-armed bursts.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

   typedef enum logic {
      LAMP_MERGED = 1'b0,
      LAMP_SPLIT  = 1'b1
   } lamp_style_e;

   // Clock cycles per toggle tick in the normal setting.
   function automatic int norm_div(input int clk_hz, input int toggle_hz);
      return clk_hz / toggle_hz;
   endfunction

   // Clock cycles per toggle tick in the test setting, never below one.
   function automatic int test_div(input int clk_hz, input int toggle_hz, input int factor);
      int d;
      d = (clk_hz / toggle_hz) / factor;
      return (d < 1) ? 1 : d;
   endfunction

endpackage

// File: rtl/phy_led_prescaler.sv
module phy_led_prescaler
   import phy_led_pkg::*;
#(
   parameter int CLK_HZ      = 25_000_000,
   parameter int TOGGLE_HZ   = 40,
   parameter int TEST_FACTOR = 8192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic test_fast,
   input  logic restart,
   output logic tick
);
   localparam int NDIV = norm_div(CLK_HZ, TOGGLE_HZ);
   localparam int TDIV = test_div(CLK_HZ, TOGGLE_HZ, TEST_FACTOR);
   localparam int CW   = (NDIV > 1) ? $clog2(NDIV + 1) : 1;

   generate
      if (NDIV < 1) begin : g_bad_div
         $error("phy_led_prescaler: CLK_HZ must be at least TOGGLE_HZ");
      end
      if (TEST_FACTOR < 2) begin : g_bad_factor
         $error("phy_led_prescaler: TEST_FACTOR must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_norm;
   logic          at_test;

   assign at_norm = (cnt_q >= CW'(NDIV - 1));

   // The test limit collapses to "every cycle" when the divided value hits one.
   generate
      if (TDIV == 1) begin : g_test_every
         assign at_test = 1'b1;
      end else begin : g_test_count
         assign at_test = (cnt_q >= CW'(TDIV - 1));
      end
   endgenerate

   assign tick = test_fast ? at_test : at_norm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/phy_led_act_hold.sv
module phy_led_act_hold #(
   parameter int HOLD_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic tick,
   output logic busy,
   output logic restart
);
   localparam int HW = $clog2(HOLD_TICKS + 1);

   generate
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("phy_led_act_hold: HOLD_TICKS must be at least 1");
      end
   endgenerate

   logic [HW-1:0] left_q;

   assign busy    = (left_q != '0);
   assign restart = strobe && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (strobe) begin
         left_q <= HW'(HOLD_TICKS);
      end else if (tick && busy) begin
         left_q <= left_q - HW'(1);
      end
   end

endmodule

// File: rtl/phy_led_phase.sv
module phy_led_phase #(
   parameter int PH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            tick,
   output logic [PH_W-1:0] phase
);
   generate
      if (PH_W < 2) begin : g_bad_width
         $error("phy_led_phase: PH_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart) begin
         phase <= '0;
      end else if (tick) begin
         phase <= phase + PH_W'(1);
      end
   end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
   import phy_led_pkg::*;
#(
   parameter int CLK_HZ      = 25_000_000,
   parameter int TOGGLE_HZ   = 40,
   parameter int TEST_FACTOR = 8192,
   parameter int HOLD_TICKS  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic speed_100,
   input  logic tx_activity,
   input  logic rx_activity,
   input  logic mode,
   input  logic blink_test,
   output logic led_link,
   output logic led_speed,
   output logic led_act
);
   localparam int PH_W = 2;

   logic            strobe;
   logic            tick;
   logic            act_busy;
   logic            act_restart;
   logic [PH_W-1:0] phase;
   logic            fast_on;
   logic            slow_on;
   lamp_style_e     style;
   logic            link_d;
   logic            act_d;
   logic            link_q;
   logic            act_q;
   logic            speed_q;

   assign strobe = tx_activity | rx_activity;
   assign style  = lamp_style_e'(mode);

   phy_led_act_hold #(
      .HOLD_TICKS (HOLD_TICKS)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe),
      .tick    (tick),
      .busy    (act_busy),
      .restart (act_restart)
   );

   phy_led_prescaler #(
      .CLK_HZ      (CLK_HZ),
      .TOGGLE_HZ   (TOGGLE_HZ),
      .TEST_FACTOR (TEST_FACTOR)
   ) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_fast (blink_test),
      .restart   (act_restart),
      .tick      (tick)
   );

   phy_led_phase #(
      .PH_W (PH_W)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (act_restart),
      .tick    (tick),
      .phase   (phase)
   );

   // Low phase bit gives the fast blink, the next bit the half-rate blink.
   assign fast_on = ~phase[0];
   assign slow_on = ~phase[1];

   always_comb begin
      act_d = link_up && act_busy && fast_on;
      unique case (style)
         LAMP_SPLIT:  link_d = link_up;
         LAMP_MERGED: link_d = link_up && (!act_busy || slow_on);
         default:     link_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         link_q <= link_d;
         act_q  <= act_d;
      end
   end

   // Speed lamp follows its input in and out of reset.
   always_ff @(posedge clk) begin
      speed_q <= speed_100;
   end

   assign led_link  = link_q;
   assign led_act   = act_q;
   assign led_speed = speed_q;

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk
   import phy_led_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic link_up,
   input logic speed_100,
   input logic tx_activity,
   input logic rx_activity,
   input logic mode,
   input logic led_link,
   input logic led_speed,
   input logic led_act,
   input logic act_busy
);

   a_r1_reset_dark: assert property (@(posedge clk)
      !rst_n |=> (!led_link && !led_act));

   a_r2_speed_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (led_speed == $past(speed_100)));

   a_r3_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (!led_link && !led_act));

   a_r4_split_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LAMP_SPLIT && link_up) |=> led_link);

   a_r5_merged_idle_on: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LAMP_MERGED && link_up && !act_busy) |=> led_link);

   a_r6_act_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      led_act |-> $past(act_busy));

   a_r7_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_activity || rx_activity) |=> act_busy);

endmodule

bind phy_led_ctrl phy_led_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .link_up     (link_up),
   .speed_100   (speed_100),
   .tx_activity (tx_activity),
   .rx_activity (rx_activity),
   .mode        (mode),
   .led_link    (led_link),
   .led_speed   (led_speed),
   .led_act     (led_act),
   .act_busy    (act_busy)
);

// File: tb/phy_led_ctrl_tb.sv
module phy_led_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 655_360;
   localparam int TOGGLE_HZ  = 40;
   localparam int FACTOR     = 8192;
   localparam int HOLD       = 4;
   localparam int D_NORM     = CLK_HZ / TOGGLE_HZ;
   localparam int D_TEST     = D_NORM / FACTOR;
   localparam int WATCHDOG   = 190_000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 1'b0;
   logic speed_100 = 1'b0;
   logic tx_activity = 1'b0;
   logic rx_activity = 1'b0;
   logic mode = 1'b0;
   logic blink_test = 1'b0;
   logic led_link;
   logic led_speed;
   logic led_act;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_led_ctrl #(
      .CLK_HZ      (CLK_HZ),
      .TOGGLE_HZ   (TOGGLE_HZ),
      .TEST_FACTOR (FACTOR),
      .HOLD_TICKS  (HOLD)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_up     (link_up),
      .speed_100   (speed_100),
      .tx_activity (tx_activity),
      .rx_activity (rx_activity),
      .mode        (mode),
      .blink_test  (blink_test),
      .led_link    (led_link),
      .led_speed   (led_speed),
      .led_act     (led_act)
   );

   task automatic chk(input logic got, input logic exp, input string req, input int n);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s at n=%0d actual=%0b expected=%0b", req, n, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   task automatic set_strobe(input logic v, input bit use_rx);
      if (use_rx) rx_activity = v;
      else        tx_activity = v;
   endtask

   // Burst: strobe held for edges E0..E(len-1), optional single re-arm at E(re_k).
   task automatic burst(input int d, input int len, input int re_k, input bit use_rx);
      int last;
      int t_end;
      string lreq;
      string areq;
      last  = (re_k > 0) ? re_k : len - 1;
      t_end = d * (last / d + HOLD);
      if (!link_up)       lreq = "R3 link lamp";
      else if (mode)      lreq = "R4 link lamp";
      else                lreq = "R5 link lamp";
      if (!link_up)       areq = "R3 traffic lamp";
      else if (use_rx)    areq = "R8 R6 R7 traffic lamp";
      else if (d == D_NORM) areq = "R9 R6 R7 traffic lamp";
      else                areq = "R6 R7 traffic lamp";
      @(negedge clk);
      set_strobe(1'b1, use_rx);
      for (int n = 0; n <= t_end + 2; n++) begin
         logic held;
         int   ph;
         logic exp_act;
         logic exp_link;
         @(negedge clk);
         held = (n >= 1) && (n <= t_end);
         ph   = (n >= 1) ? (((n - 1) / d) % 4) : 0;
         exp_act  = link_up && held && ((ph % 2) == 0);
         exp_link = link_up && (mode || !held || (ph < 2));
         chk(led_act, exp_act, areq, n);
         chk(led_link, exp_link, lreq, n);
         set_strobe(((n + 1) < len) || ((n + 1) == re_k), use_rx);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      // R1 and R2 during reset, with traffic and link present.
      link_up = 1'b1;
      tx_activity = 1'b1;
      repeat (3) @(negedge clk);
      chk(led_link, 1'b0, "R1 link lamp in reset", 0);
      chk(led_act, 1'b0, "R1 traffic lamp in reset", 0);
      speed_100 = 1'b1;
      @(negedge clk);
      chk(led_speed, 1'b1, "R2 speed in reset", 1);
      speed_100 = 1'b0;
      @(negedge clk);
      chk(led_speed, 1'b0, "R2 speed in reset", 2);
      tx_activity = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(led_link, 1'b1, "R5 idle merged link lamp", 0);
      chk(led_act, 1'b0, "R6 idle traffic lamp", 0);

      // R2 out of reset and with link down.
      speed_100 = 1'b1;
      @(negedge clk);
      chk(led_speed, 1'b1, "R2 speed 100", 0);
      link_up = 1'b0;
      speed_100 = 1'b0;
      @(negedge clk);
      chk(led_speed, 1'b0, "R2 speed 10 link down", 0);
      link_up = 1'b1;
      @(negedge clk);

      // Test setting, merged style: single pulse, long strobe, re-arm.
      blink_test = 1'b1;
      mode = 1'b0;
      burst(D_TEST, 1, 0, 1'b0);
      burst(D_TEST, 13, 0, 1'b0);
      burst(D_TEST, 1, 3, 1'b0);
      burst(D_TEST, 2, 6, 1'b1);
      burst(D_TEST, 1, 0, 1'b1);

      // Split style.
      mode = 1'b1;
      burst(D_TEST, 1, 0, 1'b0);
      burst(D_TEST, 5, 4, 1'b1);

      // Link down: lamps stay dark under traffic.
      link_up = 1'b0;
      mode = 1'b0;
      burst(D_TEST, 3, 0, 1'b0);
      link_up = 1'b1;
      @(negedge clk);

      // Normal setting: tick interval is the full division.
      blink_test = 1'b0;
      burst(D_NORM, 1, 0, 1'b0);

      finish_run();
   end

endmodule